// File: doc/BRIEF.md
# Register-Write Command Stream Interpreter

This block reads a stream of 32-bit command words, as fetched from memory by an outside engine, and turns them into register writes on a simple valid/ready write port. A stream first names its destinations with a block-select command. Write commands that follow are replayed once to each chosen destination. Each destination has its own base address: `BASE_ADDR + index * DEST_STRIDE`.

Every command has a two-word header. A single write carries its data in the header. The three burst kinds are auto-increment, fixed address and table-with-wrap. Each is followed by payload words, and every payload word becomes one write per selected destination. A block-select command whose mask is zero ends the stream and gives a one-cycle done pulse. Any illegal command sets a sticky error flag. After an error the block drains all remaining input without writing, until reset.

Top module: `cmd_stream_writer`

## Requirements
- R1: After reset `in_ready` is 1, and `wr_valid`, `err` and `done` are 0.
- R2: A header whose first word has bits 30:27 = 4'b0010 is a single write. The second word is written at relative byte offset bits 19:0 of the first word, and no payload follows.
- R3: A header whose first word is 32'h180AC060 is a block-select command, and its second word is a mask. Mask bits 0..4 select destinations 0..4 (the pipe group). Bits 17..21 select destinations 5..9 (the post group). Other bits are ignored. Each data word is written once per selected destination, in ascending destination order, at address `BASE_ADDR + idx*DEST_STRIDE + offset`.
- R4: Opcode 4'b1000 is an auto-increment burst. The second word is the payload length N, and payload word k goes to `offset + 4k`.
- R5: Opcode 4'b0110 is a fixed-address burst. Every payload word goes to the header offset.
- R6: Opcode 4'b1010 is a table burst. In the second word, bit 31 means no increment, bits 19:16 give the wrap size W, and bits 13:0 give the count N. With increment enabled, word k goes to `offset + 4*(k mod W)`. With no increment, every word goes to the offset. A length of zero in any burst issues no writes.
- R7: A write command that arrives before any block-select, or after the stream-ending select, sets `err`.
- R8: A select mask that sets bits of both groups, or that is non-zero but selects no destination, sets `err`.
- R9: Any of the following sets `err`: an unknown opcode, a wrap size below 2, a burst length above 16383, or an offset with bits 1:0 non-zero. Once `err` is set it stays set until reset, `in_ready` stays 1 and no further writes are issued.
- R10: A block-select with mask 0 raises `done` for exactly one cycle and clears the selection.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold their values. No input word is accepted while a write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word accepted when high with in_valid |
| in_word | input | 32 | Command word |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | ADDR_W | Absolute write address |
| wr_data | output | 32 | Write data |
| err | output | 1 | Sticky command error flag |
| done | output | 1 | One-cycle pulse at end of stream |

## Verification
The assertions check on every cycle that the write port is stable under back-pressure and that no command word is taken while a write waits. They also check that the error flag is sticky and silences the write port, that the done flag is a single pulse, and that write addresses are word aligned. Only the bench scenarios can show that the decoded addresses, the destination ordering, the wrap sequence of table bursts and each illegal-command case give the right write list. These scenarios include random streams with random stalls on both handshakes.

// File: rtl/cmd_stream_writer.sv
module cmd_stream_writer #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] DEST_STRIDE = 32'h0001_0000,
  parameter logic [31:0] SEL_WORD = 32'h180A_C060,
  parameter int MAX_WORDS = 16383
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              err,
  output logic              done
);
  localparam int NDEST = 10;
  localparam int IDX_W = $clog2(NDEST);
  localparam int OFF_W = 20;
  localparam int CNT_W = 14;

  typedef enum logic [2:0] {S_HDR0, S_HDR1, S_PAY, S_ISSUE, S_HALT} st_t;
  typedef enum logic [2:0] {K_SEL, K_SGL, K_INC, K_FIX, K_TAB} kind_t;

  st_t               st;
  kind_t             kind;
  logic [NDEST-1:0]  sel, pend, low;
  logic              sel_ok, noinc;
  logic [OFF_W-1:0]  off, start;
  logic [CNT_W-1:0]  rem;
  logic [3:0]        wrap, wcnt;
  logic [31:0]       data;
  logic [IDX_W-1:0]  idx;

  wire take = in_valid && in_ready;
  wire [NDEST-1:0] in_map = {in_word[21:17], in_word[4:0]};
  wire mixed = (|in_map[4:0]) && (|in_map[9:5]);

  assign in_ready = (st != S_ISSUE);
  assign wr_valid = (st == S_ISSUE) && (pend != '0);
  assign wr_data  = data;
  assign wr_addr  = BASE_ADDR + ADDR_W'(idx) * DEST_STRIDE + ADDR_W'(off);

  always_comb begin
    idx = '0;
    low = '0;
    for (int i = NDEST - 1; i >= 0; i--)
      if (pend[i]) begin
        idx = IDX_W'(i);
        low = '0;
        low[i] = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HDR0; kind <= K_SEL; sel <= '0; sel_ok <= 1'b0; pend <= '0;
      noinc <= 1'b0; off <= '0; start <= '0; rem <= '0; wrap <= '0;
      wcnt <= '0; data <= '0; err <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_HDR0: if (take) begin
          off   <= in_word[OFF_W-1:0];
          start <= in_word[OFF_W-1:0];
          st    <= S_HDR1;
          if (in_word == SEL_WORD) kind <= K_SEL;
          else begin
            case (in_word[30:27])
              4'b0010: kind <= K_SGL;
              4'b1000: kind <= K_INC;
              4'b0110: kind <= K_FIX;
              4'b1010: kind <= K_TAB;
              default: begin err <= 1'b1; st <= S_HALT; end
            endcase
            if (!sel_ok || in_word[1:0] != 2'b00) begin
              err <= 1'b1; st <= S_HALT;
            end
          end
        end
        S_HDR1: if (take) begin
          wcnt <= '0;
          st   <= S_HDR0;
          case (kind)
            K_SEL: begin
              if (in_word == '0) begin
                done <= 1'b1; sel_ok <= 1'b0; sel <= '0;
              end else if (in_map == '0 || mixed) begin
                err <= 1'b1; st <= S_HALT;
              end else begin
                sel <= in_map; sel_ok <= 1'b1;
              end
            end
            K_SGL: begin
              data <= in_word; pend <= sel; rem <= '0; st <= S_ISSUE;
            end
            K_INC, K_FIX: begin
              noinc <= (kind == K_FIX);
              wrap  <= '0;
              rem   <= in_word[CNT_W-1:0];
              if (in_word > 32'(MAX_WORDS)) begin
                err <= 1'b1; st <= S_HALT;
              end else if (in_word != '0) st <= S_PAY;
            end
            default: begin
              noinc <= in_word[31];
              wrap  <= in_word[19:16];
              rem   <= in_word[CNT_W-1:0];
              if (in_word[19:16] < 4'd2) begin
                err <= 1'b1; st <= S_HALT;
              end else if (in_word[CNT_W-1:0] != '0) st <= S_PAY;
            end
          endcase
        end
        S_PAY: if (take) begin
          data <= in_word;
          pend <= sel;
          rem  <= rem - 1'b1;
          st   <= S_ISSUE;
        end
        S_ISSUE: if (wr_ready) begin
          pend <= pend & ~low;
          if (pend == low) begin
            st <= (rem != '0) ? S_PAY : S_HDR0;
            if (!noinc) begin
              if (wrap != '0 && wcnt + 4'd1 == wrap) begin
                off <= start; wcnt <= '0;
              end else begin
                off <= off + OFF_W'(4); wcnt <= wcnt + 4'd1;
              end
            end
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  p_no_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_valid && in_ready);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00);
endmodule

// File: tb/cmd_stream_writer_test.sv
module cmd_stream_writer_test;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] STRIDE = 32'h0001_0000;
  localparam logic [31:0] SELW = 32'h180A_C060;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, wr_ready = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, wr_valid, err, done;
  logic [31:0] wr_addr, wr_data;

  int tests = 0, fails = 0;
  logic [31:0] sw[$], ea[$], ed[$];
  logic [9:0] bmask;
  int exp_done;

  always #10 clk = ~clk;

  cmd_stream_writer #(.ADDR_W(32), .BASE_ADDR(BASE), .DEST_STRIDE(STRIDE),
    .SEL_WORD(SELW), .MAX_WORDS(16383)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .err(err), .done(done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fresh();
    sw.delete(); ea.delete(); ed.delete(); bmask = '0; exp_done = 0;
  endtask

  task automatic exp_write(input logic [31:0] off, input logic [31:0] d);
    for (int i = 0; i < 10; i++)
      if (bmask[i]) begin
        ea.push_back(BASE + 32'(i) * STRIDE + off);
        ed.push_back(d);
      end
  endtask

  task automatic add_sel(input logic [31:0] m);
    sw.push_back(SELW); sw.push_back(m);
    bmask = {m[21:17], m[4:0]};
  endtask

  task automatic add_end();
    sw.push_back(SELW); sw.push_back(32'h0);
    bmask = '0; exp_done++;
  endtask

  task automatic add_single(input logic [31:0] off, input logic [31:0] d);
    sw.push_back((32'h1 << 28) | off); sw.push_back(d);
    exp_write(off, d);
  endtask

  task automatic add_burst(input bit fixed, input logic [31:0] off, input int n);
    sw.push_back((fixed ? (32'h3 << 28) : (32'h1 << 30)) | off);
    sw.push_back(32'(n));
    for (int k = 0; k < n; k++) begin
      logic [31:0] d = $urandom;
      sw.push_back(d);
      exp_write(fixed ? off : off + 32'(4 * k), d);
    end
  endtask

  task automatic add_table(input logic [31:0] off, input bit ni, input int w, input int n);
    sw.push_back((32'h5 << 28) | off);
    sw.push_back((32'(ni) << 31) | (32'(w) << 16) | 32'(n));
    for (int k = 0; k < n; k++) begin
      logic [31:0] d = $urandom;
      sw.push_back(d);
      exp_write(ni ? off : off + 32'(4 * (k % w)), d);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input string req, input bit exp_err);
    int idx = 0, got = 0, idle = 0, cyc = 0, dn = 0;
    do_reset();
    while (idle < 40) begin
      @(negedge clk);
      cyc++;
      in_valid = (idx < sw.size()) && ($urandom % 4 != 0);
      in_word  = (idx < sw.size()) ? sw[idx] : 32'h0;
      wr_ready = ($urandom % 3) != 0;
      #1;
      if (done) dn++;
      if (in_valid && in_ready) idx++;
      if (wr_valid && wr_ready) begin
        if (got < ea.size()) begin
          chk(wr_addr == ea[got], {req, " addr"}, wr_addr, ea[got]);
          chk(wr_data == ed[got], {req, " data"}, wr_data, ed[got]);
        end else chk(1'b0, {req, " extra write"}, wr_addr, 32'h0);
        got++;
      end
      if (idx == sw.size() && !wr_valid) idle++;
      if (cyc > 20000) begin
        chk(1'b0, {req, " watchdog"}, 32'(cyc), 32'd20000);
        break;
      end
    end
    in_valid = 1'b0;
    chk(got == ea.size(), {req, " write count"}, 32'(got), 32'(ea.size()));
    chk(err == exp_err, {req, " err"}, 32'(err), 32'(exp_err));
    chk(dn == exp_done, {req, " done pulses"}, 32'(dn), 32'(exp_done));
  endtask

  initial begin
    #(20ns * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    #1;
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    chk(wr_valid == 1'b0, "R1 wr_valid", 32'(wr_valid), 32'd0);
    chk(err == 1'b0, "R1 err", 32'(err), 32'd0);
    chk(done == 1'b0, "R1 done", 32'(done), 32'd0);

    fresh(); add_sel(32'h1F); add_single(32'h40, 32'hCAFE_0001);
    add_single(32'hFFFFC, 32'h1234_5678); add_end();
    run("R2 R3 pipe single", 1'b0);

    fresh(); add_sel(32'h003E_0000); add_single(32'h8, 32'hA5A5_0000);
    add_burst(1'b0, 32'h100, 5); add_end();
    run("R3 R4 post inc burst", 1'b0);

    fresh(); add_sel(32'h0001_0009); add_burst(1'b1, 32'h200, 4); add_end();
    run("R5 fixed burst, R3 ignored bit", 1'b0);

    fresh(); add_sel(32'h0014_0000); add_table(32'h300, 1'b0, 3, 7);
    add_table(32'h400, 1'b1, 2, 3); add_table(32'h500, 1'b0, 15, 16); add_end();
    run("R6 table burst", 1'b0);

    fresh(); add_sel(32'h2); add_burst(1'b0, 32'h10, 0); add_table(32'h20, 1'b0, 4, 0);
    add_sel(32'h0020_0000); add_single(32'h30, 32'h55); add_end();
    run("R6 zero length, R3 reselect", 1'b0);

    fresh(); add_sel(32'h4); add_single(32'h0, 32'h77); add_end();
    sw.push_back(32'h1 << 28); sw.push_back(32'h99);
    run("R10 R7 write after end", 1'b1);

    fresh(); sw.push_back(32'h1 << 28); sw.push_back(32'h1);
    add_sel(32'h1); sw.push_back(32'h1 << 28); sw.push_back(32'h2);
    run("R7 write before select", 1'b1);

    fresh(); add_sel(32'h1); add_single(32'h4, 32'h11);
    sw.push_back(SELW); sw.push_back(32'h0002_0001);
    sw.push_back(32'h1 << 28); sw.push_back(32'h3);
    run("R8 mixed mask", 1'b1);

    fresh(); sw.push_back(SELW); sw.push_back(32'h0000_0020);
    sw.push_back(32'h1 << 28); sw.push_back(32'h3);
    run("R8 empty mask", 1'b1);

    fresh(); add_sel(32'h1); add_single(32'h4, 32'h22);
    sw.push_back(32'h7 << 27); sw.push_back(32'h0);
    for (int k = 0; k < 6; k++) sw.push_back(32'h1 << 28);
    run("R9 unknown opcode", 1'b1);

    fresh(); add_sel(32'h1);
    sw.push_back((32'h5 << 28) | 32'h8); sw.push_back((32'h1 << 16) | 32'h2);
    sw.push_back(32'h1); sw.push_back(32'h2);
    run("R9 wrap too small", 1'b1);

    fresh(); add_sel(32'h1);
    sw.push_back(32'h1 << 30); sw.push_back(32'd16384); sw.push_back(32'h5);
    run("R9 length too large", 1'b1);

    fresh(); add_sel(32'h1);
    sw.push_back((32'h1 << 28) | 32'h102); sw.push_back(32'h5);
    run("R9 misaligned offset", 1'b1);

    for (int r = 0; r < 20; r++) begin
      fresh();
      for (int s = 0; s < 2; s++) begin
        if ($urandom % 2 == 0) add_sel(32'(($urandom % 31) + 1));
        else add_sel(32'(($urandom % 31) + 1) << 17);
        for (int c = 0; c < 4; c++) begin
          logic [31:0] off = 32'(($urandom % 4096) * 4);
          case ($urandom % 4)
            0: add_single(off, $urandom);
            1: add_burst(1'b0, off, int'($urandom % 7));
            2: add_burst(1'b1, off, int'($urandom % 7));
            default: add_table(off, 1'($urandom % 2), int'($urandom % 5) + 2, int'($urandom % 9));
          endcase
        end
      end
      add_end();
      run("R2 R4 R5 R6 R11 random", 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule